// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets software on the chip read and write the management registers of an external Ethernet PHY over a two-wire serial bus. The bus is the IEEE 802.3 Clause 22 management interface. Software sees a single 32-bit word. Writing that word launches one transaction, described entirely by the fields packed into it. Reading the word returns a busy flag, a read-valid flag and the last 16 bits of data returned by the PHY.

Internally, a divider derives the management clock (MDC) from the system clock. It runs only while a frame is in flight. A sequencer serialises the 64-bit frame onto the data line and changes the line only while MDC is low. For a read, the sequencer releases the line from the turnaround onward and shifts in the PHY's reply on each rising MDC.

The register port is a plain single-cycle write strobe with combinational read data. Back-pressure is expressed only through the busy flag: software must poll until busy reads 0 before issuing a new command. Any write made while busy is 1 is dropped without effect.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset, `csr_rdata` reads 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A command word carries the write data in bits 15:0, the PHY address in bits 20:16 and the register address in bits 25:21. Bit 26 selects the operation: 1 is a read, 0 is a write. The frame carries both address fields MSB first.
- R3: Status bit 28 (busy) reads 1 from the cycle after a command is accepted. It stays 1 for exactly 64 MDC periods (64 × `MDC_DIV` clocks).
- R4: A write frame is sent in this order: 32 ones, start code 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits MSB first. `mdio_oe` is 1 for the whole write frame, and `mdio_o` does not change while `mdc` is high.
- R5: A read frame sends 32 ones, 01, opcode 10 and the two addresses. `mdio_oe` is 0 from bit 46 (the turnaround) to the end of the frame. `mdio_i` is sampled at each rising MDC during bits 48 to 63, MSB first, and the result appears in status bits 15:0 once busy clears.
- R6: Status bit 27 (read-valid) becomes 1 when a read frame completes. It returns to 0 in the cycle after any command is accepted, and it stays 0 after a write frame.
- R7: A register write made while busy is 1 is ignored. The frame in progress, its duration, the returned read data and read-valid are all unaffected.
- R8: `mdc` has a period of `MDC_DIV` system clocks and is high for `MDC_DIV/2` of them. `mdc` stays low whenever the block is idle.
- R9: Status bits 31:29 and 26:16 always read 0. Status bits 15:0 change only when a read frame completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Write strobe for the command/status word |
| csr_wdata | input | 32 | Command word |
| csr_rdata | output | 32 | Status word: busy, read-valid, read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |
| mdio_i | input | 1 | Serial data sampled from the MDIO pad |

## Verification
The assertions take three things for granted about the inputs. `csr_we` is a single-cycle strobe. `MDC_DIV` is even and at least 4. `mdio_i` matters only in the read data window. They also rely on the PHY changing its data only after a falling MDC, so the line is settled before the rising edge on which it is sampled. The bench models such a PHY. It updates `mdio_i` only in the system-clock cycle after MDC falls, and it pulses `csr_we` for one cycle at a time, midway between clock edges. It also writes while busy only at mid-frame points, where the ignore rule is what is under test.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int TA_FIRST    = 46;
  localparam int DATA_FIRST  = 48;

  localparam int F_DATA   = 0;
  localparam int F_PHY    = 16;
  localparam int F_REG    = 21;
  localparam int F_OP     = 26;
  localparam int F_RVALID = 27;
  localparam int F_BUSY   = 28;

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  function automatic mdio_cmd_t unpack_cmd(input logic [26:0] w);
    mdio_cmd_t c;
    c.is_read = w[F_OP];
    c.phy     = w[F_PHY +: ADDR_W];
    c.regad   = w[F_REG +: ADDR_W];
    c.wdata   = w[F_DATA +: DATA_W];
    return c;
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == CNT_LAST);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_EDGE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(rise_stb)) else $error("mdc rose without strobe"); // R8

  AST_MDC_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdc) && $past(run)) |-> $past(fall_stb)) else $error("mdc fell without strobe"); // R8

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              done_read,
  output logic [DATA_W-1:0] rd_word
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] BIT_TA    = BW'(TA_FIRST);
  localparam logic [BW-1:0] BIT_DATA  = BW'(DATA_FIRST);

  logic [FRAME_BITS-1:0] shreg;
  logic [BW-1:0]         bitc;
  logic                  is_read;
  logic [DATA_W-1:0]     rdsh;
  logic [FRAME_BITS-1:0] load_word;

  always_comb begin
    load_word = {{PRE_BITS{1'b1}}, 2'b01,
                 cmd.is_read ? 2'b10 : 2'b01,
                 cmd.phy, cmd.regad,
                 cmd.is_read ? 2'b00 : 2'b10,
                 cmd.is_read ? {DATA_W{1'b0}} : cmd.wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitc    <= '0;
      busy    <= 1'b0;
      is_read <= 1'b0;
      rdsh    <= '0;
    end else if (start) begin
      shreg   <= load_word;
      bitc    <= '0;
      busy    <= 1'b1;
      is_read <= cmd.is_read;
      rdsh    <= '0;
    end else if (busy) begin
      if (rise_stb && is_read && (bitc >= BIT_DATA))
        rdsh <= {rdsh[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        if (bitc == BIT_LAST) busy <= 1'b0;
        else                  bitc <= bitc + 1'b1;
      end
    end
  end

  assign mdio_o    = shreg[FRAME_BITS-1];
  assign mdio_oe   = busy && !(is_read && (bitc >= BIT_TA));
  assign done      = busy && fall_stb && (bitc == BIT_LAST);
  assign done_read = is_read;
  assign rd_word   = rdsh;

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start) else $error("start accepted during frame"); // R7

  AST_WRITE_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_read) |-> mdio_oe) else $error("write frame released line"); // R4

  AST_READ_RELEASED_AFTER_TA: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_read && bitc > BIT_TA) |-> !mdio_oe) else $error("read data window driven"); // R5

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_read,
  input  logic [DATA_W-1:0] rd_word,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic [31:0]       rdata
);
  logic              rvalid;
  logic [DATA_W-1:0] rd_q;
  logic              unused_hi;

  assign unused_hi = ^wdata[31:27];
  assign start     = we && !busy;
  assign cmd       = unpack_cmd(wdata[26:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rd_q   <= '0;
    end else if (start) begin
      rvalid <= 1'b0;
    end else if (done && done_read) begin
      rvalid <= 1'b1;
      rd_q   <= rd_word;
    end
  end

  always_comb begin
    rdata                     = '0;
    rdata[F_DATA +: DATA_W]   = rd_q;
    rdata[F_RVALID]           = rvalid;
    rdata[F_BUSY]             = busy;
  end

  AST_RVALID_CLEARED_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rvalid) else $error("read-valid survived new command"); // R6

  AST_RVALID_SET_ON_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_read) |=> (rvalid && !busy)) else $error("read completion not flagged"); // R6

  AST_DATA_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(rd_q)) else $error("read data moved mid-frame"); // R9

endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
  import mdio_pkg::*;
#(
  parameter int MDC_DIV = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              start;
  mdio_cmd_t         cmd;
  logic              busy;
  logic              done;
  logic              done_read;
  logic [DATA_W-1:0] rd_word;
  logic              rise_stb;
  logic              fall_stb;

  mdio_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (csr_we),
    .wdata     (csr_wdata),
    .busy      (busy),
    .done      (done),
    .done_read (done_read),
    .rd_word   (rd_word),
    .start     (start),
    .cmd       (cmd),
    .rdata     (csr_rdata)
  );

  mdio_clkdiv #(.DIV(MDC_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .done      (done),
    .done_read (done_read),
    .rd_word   (rd_word)
  );

  AST_MDIO_HOLD_WHILE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o)) else $error("mdio changed with mdc high"); // R4

  AST_MDC_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[F_BUSY] |-> !mdc) else $error("mdc toggling while idle"); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:29] == 3'b0) && (csr_rdata[26:16] == 11'b0)) else $error("reserved status bits set"); // R9

endmodule

// File: tb/tb_mdio_c22_master.sv
module tb_mdio_c22_master;
  localparam int DIV = 4;
  localparam int FRAME_CLKS = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i_drv = 1'b1;

  always #4 clk = ~clk;

  mdio_c22_master #(.MDC_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i_drv)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  // PHY model and wire monitor, all at the falling system clock edge
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_word = '0;
  int   pos = 0, since = 0, hi = 0, per_bad = 0;
  logic mdc_q = 1'b0;

  always @(negedge clk) begin
    if (!csr_rdata[28]) begin
      pos = 0;
      mdio_i_drv = 1'b1;
    end else begin
      if (mdc && !mdc_q) begin
        if (pos < 64) begin
          cap_o[63-pos]  = mdio_o;
          cap_oe[63-pos] = mdio_oe;
        end
        if (pos > 0 && since != DIV) per_bad++;
        since = 0;
        hi = 0;
        pos++;
      end
      if (!mdc && mdc_q) begin
        if (hi != DIV/2) per_bad++;
        mdio_i_drv = (pos >= 48 && pos <= 63) ? phy_word[63-pos] : 1'b1;
      end
      since++;
      if (mdc) hi++;
    end
    mdc_q = mdc;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {5'b0, rd, ra, phy, d};
  endfunction

  function automatic logic [63:0] wr_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d};
  endfunction

  function automatic logic [45:0] rd_head(input logic [4:0] phy, input logic [4:0] ra);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra};
  endfunction

  // issue a command; optionally write another word at busy count inj_at
  task automatic run_cmd(input logic [31:0] w, input int inj_at, input logic [31:0] inj, output int bcnt);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = w;
    @(negedge clk);
    csr_we = 1'b0;
    bcnt = 0;
    while (csr_rdata[28] && bcnt < 4 * FRAME_CLKS) begin
      bcnt++;
      if (bcnt == inj_at) begin csr_we = 1'b1; csr_wdata = inj; end
      else csr_we = 1'b0;
      @(negedge clk);
    end
    csr_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int bc, pb;
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csr_rdata == 32'h0, "R1 rdata", 64'(csr_rdata), 64'h0);
    chk(mdc == 1'b0, "R1 mdc", 64'(mdc), 64'h0);
    chk(mdio_oe == 1'b0, "R1 oe", 64'(mdio_oe), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // write sweep over every PHY address
    for (int p = 0; p < 32; p++) begin
      logic [4:0]  ra = 5'((p * 7 + 3) % 32);
      logic [15:0] d  = 16'(p * 16'h0931) ^ 16'hA5C3;
      pb = per_bad;
      run_cmd(mk(1'b0, 5'(p), ra, d), 0, 32'h0, bc);
      chk(bc == FRAME_CLKS, "R3 busy length write", 64'(bc), 64'(FRAME_CLKS));
      chk(cap_o == wr_frame(5'(p), ra, d), "R2 R4 write frame", cap_o, wr_frame(5'(p), ra, d));
      chk(cap_oe == {64{1'b1}}, "R4 write oe", cap_oe, {64{1'b1}});
      chk(per_bad == pb, "R8 mdc period/duty", 64'(per_bad), 64'(pb));
      chk(csr_rdata[27] == 1'b0, "R6 no rvalid after write", 64'(csr_rdata[27]), 64'h0);
      chk(csr_rdata[15:0] == 16'h0, "R9 data untouched by write", 64'(csr_rdata[15:0]), 64'h0);
      chk(csr_rdata[31:29] == 3'b0 && csr_rdata[26:16] == 11'b0, "R9 reserved zero",
          64'(csr_rdata), 64'(csr_rdata[15:0]));
    end

    // read sweep
    for (int k = 0; k < 16; k++) begin
      logic [4:0] p  = 5'(k * 2 + 1);
      logic [4:0] ra = 5'(31 - k);
      phy_word = 16'(16'hFFFF >> k) ^ 16'(k * 16'h1111);
      run_cmd(mk(1'b1, p, ra, 16'hBEEF), 0, 32'h0, bc);
      chk(bc == FRAME_CLKS, "R3 busy length read", 64'(bc), 64'(FRAME_CLKS));
      chk(cap_o[63:18] == rd_head(p, ra), "R2 R5 read header", 64'(cap_o[63:18]), 64'(rd_head(p, ra)));
      chk(cap_oe == {{46{1'b1}}, 18'b0}, "R5 read oe", cap_oe, {{46{1'b1}}, 18'b0});
      chk(csr_rdata[27] == 1'b1, "R6 rvalid after read", 64'(csr_rdata[27]), 64'h1);
      chk(csr_rdata[15:0] == phy_word, "R5 read data", 64'(csr_rdata[15:0]), 64'(phy_word));
    end

    // R6 accept clears read-valid in the next cycle
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = mk(1'b0, 5'd3, 5'd4, 16'h1234);
    @(negedge clk);
    csr_we = 1'b0;
    chk(csr_rdata[27] == 1'b0, "R6 rvalid cleared on accept", 64'(csr_rdata[27]), 64'h0);
    chk(csr_rdata[28] == 1'b1, "R3 busy next cycle", 64'(csr_rdata[28]), 64'h1);
    while (csr_rdata[28]) @(negedge clk);

    // R7 write during a read is ignored
    phy_word = 16'h5A3C;
    run_cmd(mk(1'b1, 5'd9, 5'd17, 16'h0), 100, mk(1'b0, 5'd30, 5'd2, 16'hFFFF), bc);
    chk(bc == FRAME_CLKS, "R7 read length kept", 64'(bc), 64'(FRAME_CLKS));
    chk(cap_o[63:18] == rd_head(5'd9, 5'd17), "R7 read frame kept", 64'(cap_o[63:18]), 64'(rd_head(5'd9, 5'd17)));
    chk(csr_rdata[27] == 1'b1, "R7 rvalid kept", 64'(csr_rdata[27]), 64'h1);
    chk(csr_rdata[15:0] == 16'h5A3C, "R7 read data kept", 64'(csr_rdata[15:0]), 64'h5A3C);
    keep = csr_rdata[15:0];

    // R7 read during a write is ignored
    phy_word = 16'h0F0F;
    run_cmd(mk(1'b0, 5'd21, 5'd11, 16'hC001), 150, mk(1'b1, 5'd1, 5'd1, 16'h0), bc);
    chk(bc == FRAME_CLKS, "R7 write length kept", 64'(bc), 64'(FRAME_CLKS));
    chk(cap_o == wr_frame(5'd21, 5'd11, 16'hC001), "R7 write frame kept", cap_o, wr_frame(5'd21, 5'd11, 16'hC001));
    chk(csr_rdata[15:0] == keep, "R7 R9 data unchanged", 64'(csr_rdata[15:0]), 64'(keep));
    chk(csr_rdata[27] == 1'b0, "R6 rvalid low after write", 64'(csr_rdata[27]), 64'h0);

    // R8 idle mdc stays low
    begin
      int hi_seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mdc) hi_seen++;
      end
      chk(hi_seen == 0, "R8 mdc idle low", 64'(hi_seen), 64'h0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule